// File: doc/BRIEF.md
# Event Interrupt Aggregator

The block collects one-cycle event pulses from neighbouring hardware units into a 32-bit pending register. It drives one level-sensitive interrupt line towards the host. Each event input is tied to one fixed bit of the pending register. The bit latches on the pulse and stays set until software clears it. Software can also raise any implemented bit itself, through a dedicated write-to-set offset. This is useful for testing handlers and for forwarding events from firmware.

A per-bit enable register gates which pending bits reach the interrupt line. Its polarity is inverted: a mask bit holding 0 lets the matching pending bit through, and a 1 blocks it. Out of reset every bit is blocked. The host reaches the three registers through a simple word-wide register port. Reads return data one cycle after the request.

Top module: `evt_irq_top`

## Requirements
- R1: Reset leaves the pending register at 0, the mask register at 0xFFFFFFFF and the interrupt output low.
- R2: A one-cycle pulse on event input i sets pending bit i at the next clock edge. The bit then stays set while no clear write names it.
- R3: A write to offset 0x44 sets every pending bit whose write-data bit is 1. The other pending bits are left as they were.
- R4: A write to offset 0x40 clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R5: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x48 loads all 32 bits of the mask register. A read of 0x48 returns the mask, and the mask does not change without a write.
- R7: The interrupt output is a register. It is high exactly when, one clock earlier, some pending bit was 1 while its mask bit was 0.
- R8: Pending bits 26 and 23 are not implemented: they read as 0 and cannot be set by events or by set writes. The implemented-bit pattern is 0xFB7FFFFF.
- R9: Event inputs map to fixed positions, and the event index equals the pending bit. Positions 31..28 are encoder capture start, end of stream, VBI capture and input reset. Position 27 is encoder DMA done, 20 is decoder DMA done and 18 is a decoder DMA list error.
- R10: A read returns its data on the cycle after the request. Offset 0x44 and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| hw_evt | input | 32 | One-cycle event pulses, one per pending bit |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions check the following on every cycle:
- each bit latches after an event, a set write or a clear write;
- an event wins over a clear on the same bit;
- the mask holds while it is not written;
- a raised interrupt always has an unmasked pending source behind it;
- status reads never show the unimplemented bits.

Only the bench scenarios can show the full read values and the exact timing of the interrupt level. They drive the block against a reference model of the registers under mixed random traffic. That covers the reset values, the inverted mask polarity, the zero reads of the set offset and unmapped offsets, and the fixed event positions.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_SET    = 2'd2,
      SEL_MASK   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
   parameter int              DATA_W     = 32,
   parameter logic [DATA_W-1:0] VALID_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt,
   input  logic              clr_we,
   input  logic              set_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] status
);
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] set_vec;

   assign clr_vec = clr_we ? wdata : '0;
   assign set_vec = set_we ? wdata : '0;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic nxt;
      always_comb begin
         nxt = status[i];
         if (clr_vec[i]) nxt = 1'b0;
         if (set_vec[i] || evt[i]) nxt = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[i] <= 1'b0;
         else        status[i] <= nxt & VALID_MASK[i];
      end
   end

   // R5
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(evt) & VALID_MASK) & ~status) == '0));
   // R3
   set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((($past(wdata) & VALID_MASK) & ~status) == '0));
   // R4
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((($past(wdata) & ~$past(evt)) & status) == '0));
   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> (($past(status) & ~status) == '0));
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
   parameter int                DATA_W    = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask <= RESET_VAL;
      else if (we) mask <= wdata;
   end

   // R6
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(mask));
   // R6
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mask == $past(wdata)));
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] status,
   input  logic [DATA_W-1:0] mask,
   output logic              irq
);
   logic pend;
   assign pend = |(status & ~mask);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pend;
      end
      // R7
      irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(|(status & ~mask)));
   end else begin : g_comb
      assign irq = pend;
   end
endmodule

// File: rtl/evt_irq_top.sv
module evt_irq_top
   import evt_irq_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] OFS_STATUS = 'h40,
   parameter logic [ADDR_W-1:0] OFS_SET    = 'h44,
   parameter logic [ADDR_W-1:0] OFS_MASK   = 'h48,
   parameter logic [DATA_W-1:0] VALID_BITS = 32'hFB7F_FFFF,
   parameter logic [DATA_W-1:0] MASK_RST   = '1,
   parameter bit                IRQ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] hw_evt,
   output logic              irq
);
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("evt_irq_top: widths must be positive");
   end
   if (OFS_STATUS == OFS_SET || OFS_STATUS == OFS_MASK || OFS_SET == OFS_MASK) begin : g_bad_ofs
      $error("evt_irq_top: register offsets must differ");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] mask;
   logic              wr, rd;

   assign wr = bus_en & bus_we;
   assign rd = bus_en & ~bus_we;

   always_comb begin
      if      (bus_addr == OFS_STATUS) sel = SEL_STATUS;
      else if (bus_addr == OFS_SET)    sel = SEL_SET;
      else if (bus_addr == OFS_MASK)   sel = SEL_MASK;
      else                             sel = SEL_NONE;
   end

   evt_irq_status #(.DATA_W(DATA_W), .VALID_MASK(VALID_BITS)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (hw_evt),
      .clr_we (wr && sel == SEL_STATUS),
      .set_we (wr && sel == SEL_SET),
      .wdata  (bus_wdata),
      .status (status)
   );

   evt_irq_mask #(.DATA_W(DATA_W), .RESET_VAL(MASK_RST)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr && sel == SEL_MASK),
      .wdata (bus_wdata),
      .mask  (mask)
   );

   evt_irq_out #(.DATA_W(DATA_W), .IRQ_REG(IRQ_REG)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status),
      .mask   (mask),
      .irq    (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else if (rd) begin
         case (sel)
            SEL_STATUS: bus_rdata <= status;
            SEL_MASK:   bus_rdata <= mask;
            default:    bus_rdata <= '0;
         endcase
      end
   end

   // R8
   reserved_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == OFS_STATUS) |=> ((bus_rdata & ~VALID_BITS) == '0));
   // R10
   set_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == OFS_SET) |=> (bus_rdata == '0));
endmodule

// File: tb/evt_irq_top_bench.sv
`timescale 1ns/1ps
module evt_irq_top_bench;
   localparam logic [31:0] VALID = 32'hFB7F_FFFF;
   localparam logic [7:0]  A_ST = 8'h40, A_SET = 8'h44, A_MK = 8'h48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, hw_evt = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_st, m_mk;

   always #2 clk = ~clk;

   evt_irq_top u_evt_irq_top (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hw_evt(hw_evt), .irq(irq)
   );

   function automatic logic [31:0] rd_model(logic [7:0] a);
      if (a == A_ST) return m_st;
      if (a == A_MK) return m_mk;
      return 32'h0;
   endfunction

   function automatic logic [31:0] st_next(logic we, logic [7:0] a, logic [31:0] wd, logic [31:0] ev);
      logic [31:0] s = m_st;
      if (we && a == A_ST)  s = s & ~wd;
      if (we && a == A_SET) s = s | wd;
      s = (s | ev) & VALID;
      return s;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One bus cycle plus event vector; checks irq and (for reads) rdata.
   task automatic cyc(string tag, logic en, logic we, logic [7:0] a, logic [31:0] wd, logic [31:0] ev);
      logic        exp_irq = |(m_st & ~m_mk);
      logic [31:0] exp_rd  = rd_model(a);
      bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd; hw_evt = ev;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; hw_evt = '0;
      chk("R7 irq level", {31'b0, irq}, {31'b0, exp_irq});
      if (en && !we) chk(tag, bus_rdata, exp_rd);
      if (en && we && a == A_MK) m_mk = wd;
      m_st = st_next(en && we, a, wd, ev);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int seed;
      m_st = '0; m_mk = '1;
      repeat (3) @(negedge clk);
      chk("R1 irq reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc("R1 status reset", 1, 0, A_ST, 0, 0);
      cyc("R1 mask reset", 1, 0, A_MK, 0, 0);
      // R9: fixed event positions 27, 20, 18 with all masked
      cyc("R9 evt", 0, 0, 0, 0, 32'h0800_0000);
      cyc("R9 evt27 read", 1, 0, A_ST, 0, 0);
      chk("R7 masked irq low", {31'b0, irq}, 32'h0);
      cyc("R6 mask write", 1, 1, A_MK, 32'h0, 0);
      cyc("R6 mask read", 1, 0, A_MK, 0, 0);
      chk("R7 unmasked irq high", {31'b0, irq}, 32'h1);
      cyc("R9 evt", 0, 0, 0, 0, 32'h0014_0000);
      cyc("R9 evt20/18 read", 1, 0, A_ST, 0, 0);
      cyc("R2 hold read", 1, 0, A_ST, 0, 0);
      // R4: clear one bit, write zero changes nothing
      cyc("R4 clr", 1, 1, A_ST, 32'h0800_0000, 0);
      cyc("R4 clr read", 1, 0, A_ST, 0, 0);
      cyc("R4 zero", 1, 1, A_ST, 32'h0, 0);
      cyc("R4 zero read", 1, 0, A_ST, 0, 0);
      // R3 set offset, R10 set offset reads zero
      cyc("R3 set", 1, 1, A_SET, 32'h0000_00F0, 0);
      cyc("R3 set read", 1, 0, A_ST, 0, 0);
      cyc("R10 set ofs read zero", 1, 0, A_SET, 0, 0);
      cyc("R10 unmapped read zero", 1, 0, 8'h4C, 0, 0);
      // R5 event beats clear
      cyc("R5 evt+clr", 1, 1, A_ST, 32'h0000_0020, 32'h0000_0020);
      cyc("R5 read", 1, 0, A_ST, 0, 0);
      // R8 reserved bits
      cyc("R8 set all", 1, 1, A_SET, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      cyc("R8 read", 1, 0, A_ST, 0, 0);
      chk("R8 bits 26/23 zero", bus_rdata & 32'h0480_0000, 32'h0);
      cyc("R7 mask all", 1, 1, A_MK, 32'hFFFF_FFFF, 0);
      cyc("R7 idle", 0, 0, 0, 0, 0);
      chk("R7 all masked irq low", {31'b0, irq}, 32'h0);
      cyc("R4 clear all", 1, 1, A_ST, 32'hFFFF_FFFF, 0);
      // constrained random traffic
      seed = $urandom(32'd20240607);
      for (int k = 0; k < 3000; k++) begin
         logic [1:0]  pick = 2'($urandom_range(0, 3));
         logic [7:0]  a    = (pick == 0) ? A_ST : (pick == 1) ? A_SET : (pick == 2) ? A_MK : 8'h4C;
         logic        en   = ($urandom_range(0, 3) != 0);
         logic        we   = $urandom_range(0, 1) == 1;
         logic [31:0] wd   = $urandom & $urandom;
         logic [31:0] ev   = $urandom & $urandom & $urandom;
         if (a == A_MK && we) wd = wd | $urandom;
         cyc("R2 random read", en, we, a, wd, ev);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule